// File: doc/BRIEF.md
# 4B/5B Symbol Codec for a 100 Mb/s PCS

This block sits between a nibble-wide media-independent interface and an already aligned 5-bit symbol stream. On the transmit side it turns a stream of nibbles, framed by a transmit-enable and qualified by a transmit-error input, into 5-bit code groups. Outside a frame it sends idle. At the start of a frame it sends a start delimiter, then encoded data. When the frame ends it sends an end delimiter and returns to idle. A test-mode input makes the transmitter emit a deliberately illegal code group instead of data whenever transmit-error is held.

On the receive side every incoming code group is sorted into one of eight classes: data, idle, the two start-delimiter halves, the two end-delimiter halves, halt, and invalid. The 10 undefined patterns are the invalid class. A receive state machine opens a frame only after the two start-delimiter halves arrive back to back. A lone first half is reported as a false carrier. Two sticky flags record invalid and halt code groups, and a status-read strobe clears them.

Transmit states: `TX_IDLE` (sends /I/), `TX_SSD2` (sends /K/), `TX_DATA` (sends data, /H/ or the test pattern), `TX_ESD2` (sends /R/). The transitions are `TX_IDLE→TX_SSD2` when tx_en is high, `TX_SSD2→TX_DATA` always, `TX_DATA→TX_ESD2` when tx_en is low, and `TX_ESD2→TX_IDLE` always. Receive states: `RX_IDLE`, `RX_GOTJ`, `RX_FRAME`, `RX_GOTT`. The transitions are `RX_IDLE→RX_GOTJ` on /J/, `RX_GOTJ→RX_FRAME` on /K/, `RX_GOTJ→RX_IDLE` on anything else (false carrier), `RX_FRAME→RX_GOTT` on /T/, and `RX_GOTT→RX_IDLE` always.

Top module: `pcs_symbol_codec`

## Requirements
- R1: Inside a frame with tx_er low, tx_sym carries the data code of the nibble sampled one clock earlier. Nibbles 0x0 to 0xF map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R2: Outside a frame, tx_sym is the idle code 11111.
- R3: On the clock where tx_en is first sampled high, tx_sym becomes /J/ (11000), and on the next clock /K/ (10001). The nibbles in those two slots are dropped.
- R4: Once tx_en is sampled low inside a frame, tx_sym is /T/ (01101), then /R/ (00111), then idle.
- R5: Inside a frame with tx_er high and tx_test_inv low, tx_sym is /H/ (00100) instead of the data code.
- R6: Inside a frame with tx_er high and tx_test_inv high, tx_sym is the illegal code 00000.
- R7: rx_dv goes high only for data slots after /J/ directly followed by /K/. It is low for the delimiter slots. When rx_dv is high, rx_nibble holds the decoded nibble one clock after the code group was sampled. rx_nibble is 0 when rx_dv is low.
- R8: A /J/ followed by anything other than /K/ pulses rx_false_carrier for one clock and produces no rx_dv.
- R9: Inside a frame, any non-data code group other than /T/ asserts rx_err (with rx_dv) for that slot.
- R10: Receiving any of the 10 undefined code groups sets stat_invalid on the next clock, and receiving /H/ sets stat_halt, anywhere in the stream.
- R11: Both flags hold until status_rd is high. A flag whose event coincides with status_rd stays set.
- R12: After reset, tx_sym is idle, rx_dv, rx_err and rx_false_carrier are low, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit frame enable |
| tx_er | input | 1 | Transmit error qualifier |
| tx_nibble | input | 4 | Transmit data nibble |
| tx_test_inv | input | 1 | Test mode: send illegal code while tx_er is high |
| tx_sym | output | 5 | Transmitted code group |
| rx_sym | input | 5 | Received aligned code group |
| rx_nibble | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_err | output | 1 | Receive error for this slot |
| rx_false_carrier | output | 1 | One-clock false-carrier pulse |
| status_rd | input | 1 | Status read strobe, clears flags |
| stat_invalid | output | 1 | Sticky invalid code group flag |
| stat_halt | output | 1 | Sticky halt flag |

## Verification
The properties assume that reset is held for at least one clock and that every input changes only away from the rising edge. The receive properties also assume that rx_sym carries a code group every clock, with no gaps in alignment. The bench drives every input on the falling edge. Its random receive stream is biased so that /J/ is usually followed by /K/: this produces real frames as well as false carriers, and still mixes in halt, invalid and stray delimiters at any point.

// File: rtl/pcs_codec_pkg.sv
package pcs_codec_pkg;
    parameter int NIB_W = 4;
    parameter int SYM_W = 5;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t SYM_I   = SYM_W'(5'b11111);
    localparam sym_t SYM_J   = SYM_W'(5'b11000);
    localparam sym_t SYM_K   = SYM_W'(5'b10001);
    localparam sym_t SYM_T   = SYM_W'(5'b01101);
    localparam sym_t SYM_R   = SYM_W'(5'b00111);
    localparam sym_t SYM_H   = SYM_W'(5'b00100);
    localparam sym_t SYM_BAD = SYM_W'(5'b00000);

    typedef enum logic [2:0] {
        CL_DATA, CL_IDLE, CL_SSD1, CL_SSD2, CL_ESD1, CL_ESD2, CL_HALT, CL_BAD
    } sym_class_e;

    typedef struct packed {
        sym_class_e cls;
        nib_t       nib;
    } sym_info_t;

    function automatic sym_t nib_to_sym(nib_t n);
        sym_t s;
        unique case (n)
            4'h0: s = 5'b11110;  4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;  4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;  4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;  4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;  4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;  4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;  4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;  default: s = 5'b11101;
        endcase
        return s;
    endfunction

    function automatic sym_info_t classify(sym_t s);
        sym_info_t r;
        r.cls = CL_BAD;
        r.nib = '0;
        for (int n = 0; n < (1 << NIB_W); n++) begin
            if (nib_to_sym(nib_t'(n)) == s) begin
                r.cls = CL_DATA;
                r.nib = nib_t'(n);
            end
        end
        if (r.cls != CL_DATA) begin
            case (s)
                SYM_I:   r.cls = CL_IDLE;
                SYM_J:   r.cls = CL_SSD1;
                SYM_K:   r.cls = CL_SSD2;
                SYM_T:   r.cls = CL_ESD1;
                SYM_R:   r.cls = CL_ESD2;
                SYM_H:   r.cls = CL_HALT;
                default: r.cls = CL_BAD;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
    import pcs_codec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_er,
    input  logic test_inv,
    input  nib_t tx_nib,
    output sym_t tx_sym
);
    typedef enum logic [1:0] {TX_IDLE, TX_SSD2, TX_DATA, TX_ESD2} tx_state_e;

    tx_state_e state_q, state_d;
    sym_t      sym_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            tx_sym  <= SYM_I;
        end else begin
            state_q <= state_d;
            tx_sym  <= sym_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sym_d   = SYM_I;
        unique case (state_q)
            TX_IDLE: begin
                if (tx_en) begin
                    sym_d   = SYM_J;
                    state_d = TX_SSD2;
                end
            end
            TX_SSD2: begin
                sym_d   = SYM_K;
                state_d = TX_DATA;
            end
            TX_DATA: begin
                if (!tx_en) begin
                    sym_d   = SYM_T;
                    state_d = TX_ESD2;
                end else if (tx_er) begin
                    sym_d = test_inv ? SYM_BAD : SYM_H;
                end else begin
                    sym_d = nib_to_sym(tx_nib);
                end
            end
            TX_ESD2: begin
                sym_d   = SYM_R;
                state_d = TX_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
    import pcs_codec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_t rx_sym,
    output nib_t rx_nib,
    output logic rx_dv,
    output logic rx_err,
    output logic false_carrier
);
    typedef enum logic [1:0] {RX_IDLE, RX_GOTJ, RX_FRAME, RX_GOTT} rx_state_e;

    rx_state_e state_q, state_d;
    sym_info_t info;
    nib_t      nib_d;
    logic      dv_d, err_d, fc_d;

    assign info = classify(rx_sym);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= RX_IDLE;
            rx_nib        <= '0;
            rx_dv         <= 1'b0;
            rx_err        <= 1'b0;
            false_carrier <= 1'b0;
        end else begin
            state_q       <= state_d;
            rx_nib        <= nib_d;
            rx_dv         <= dv_d;
            rx_err        <= err_d;
            false_carrier <= fc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        nib_d   = '0;
        dv_d    = 1'b0;
        err_d   = 1'b0;
        fc_d    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (info.cls == CL_SSD1) state_d = RX_GOTJ;
            end
            RX_GOTJ: begin
                if (info.cls == CL_SSD2) begin
                    state_d = RX_FRAME;
                end else begin
                    fc_d    = 1'b1;
                    state_d = RX_IDLE;
                end
            end
            RX_FRAME: begin
                if (info.cls == CL_ESD1) begin
                    state_d = RX_GOTT;
                end else begin
                    dv_d = 1'b1;
                    if (info.cls == CL_DATA) nib_d = info.nib;
                    else                     err_d = 1'b1;
                end
            end
            RX_GOTT: begin
                state_d = RX_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pcs_status_flags.sv
module pcs_status_flags
    import pcs_codec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_t rx_sym,
    input  logic clr,
    output logic flag_invalid,
    output logic flag_halt
);
    sym_info_t info;
    logic      ev_bad, ev_halt;

    assign info    = classify(rx_sym);
    assign ev_bad  = (info.cls == CL_BAD);
    assign ev_halt = (info.cls == CL_HALT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_invalid <= 1'b0;
            flag_halt    <= 1'b0;
        end else begin
            flag_invalid <= (flag_invalid & ~clr) | ev_bad;
            flag_halt    <= (flag_halt & ~clr) | ev_halt;
        end
    end
endmodule

// File: rtl/pcs_symbol_codec.sv
module pcs_symbol_codec
    import pcs_codec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [3:0] tx_nibble,
    input  logic       tx_test_inv,
    output logic [4:0] tx_sym,
    input  logic [4:0] rx_sym,
    output logic [3:0] rx_nibble,
    output logic       rx_dv,
    output logic       rx_err,
    output logic       rx_false_carrier,
    input  logic       status_rd,
    output logic       stat_invalid,
    output logic       stat_halt
);
    pcs_tx_encoder u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
        .test_inv(tx_test_inv), .tx_nib(tx_nibble), .tx_sym(tx_sym)
    );

    pcs_rx_decoder u_rx (
        .clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .rx_nib(rx_nibble),
        .rx_dv(rx_dv), .rx_err(rx_err), .false_carrier(rx_false_carrier)
    );

    pcs_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .clr(status_rd),
        .flag_invalid(stat_invalid), .flag_halt(stat_halt)
    );
endmodule

// File: rtl/pcs_codec_checker.sv
module pcs_codec_checker
    import pcs_codec_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] tx_sym,
    input logic [4:0] rx_sym,
    input logic       rx_dv,
    input logic       rx_err,
    input logic       rx_false_carrier,
    input logic       status_rd,
    input logic       stat_invalid,
    input logic       stat_halt
);
    assert_k_after_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sym == SYM_K) |-> ($past(tx_sym) == SYM_J));

    assert_r_after_t_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sym == SYM_R) |-> ($past(tx_sym) == SYM_T));

    assert_dv_needs_ssd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> ($past(rx_sym, 2) == SYM_K));

    assert_fc_no_dv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_false_carrier |-> !rx_dv);

    assert_err_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> rx_dv);

    assert_halt_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sym == SYM_H) |=> stat_halt);

    assert_invalid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_invalid && !status_rd) |=> stat_invalid);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_halt && !status_rd) |=> stat_halt);
endmodule

bind pcs_symbol_codec pcs_codec_checker chk_i (
    .clk(clk), .rst_n(rst_n), .tx_sym(tx_sym), .rx_sym(rx_sym),
    .rx_dv(rx_dv), .rx_err(rx_err), .rx_false_carrier(rx_false_carrier),
    .status_rd(status_rd), .stat_invalid(stat_invalid), .stat_halt(stat_halt)
);

// File: tb/pcs_symbol_codec_tb.sv
`timescale 1ns/1ps
module pcs_symbol_codec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_er = 1'b0, tx_test_inv = 1'b0, status_rd = 1'b0;
    logic [3:0] tx_nibble = 4'h0;
    logic [4:0] rx_sym = 5'b11111;
    logic [4:0] tx_sym;
    logic [3:0] rx_nibble;
    logic       rx_dv, rx_err, rx_false_carrier, stat_invalid, stat_halt;

    int nchk = 0, nerr = 0;
    int txs = 0, rxs = 0;
    bit inv_f = 0, halt_f = 0;

    always #2.5 clk = ~clk;

    pcs_symbol_codec dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
        .tx_nibble(tx_nibble), .tx_test_inv(tx_test_inv), .tx_sym(tx_sym),
        .rx_sym(rx_sym), .rx_nibble(rx_nibble), .rx_dv(rx_dv), .rx_err(rx_err),
        .rx_false_carrier(rx_false_carrier), .status_rd(status_rd),
        .stat_invalid(stat_invalid), .stat_halt(stat_halt)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic bit is_data(input logic [4:0] s, output logic [3:0] n);
        n = 4'h0;
        for (int i = 0; i < 16; i++) if (enc(4'(i)) == s) begin n = 4'(i); return 1; end
        return 0;
    endfunction

    function automatic bit is_ctrl(input logic [4:0] s);
        return s == 5'b11111 || s == 5'b11000 || s == 5'b10001 ||
               s == 5'b01101 || s == 5'b00111 || s == 5'b00100;
    endfunction

    function automatic logic [4:0] pick_invalid(input int k);
        int c = 0;
        logic [3:0] d;
        for (int s = 0; s < 32; s++) begin
            if (!is_data(5'(s), d) && !is_ctrl(5'(s))) begin
                if (c == k % 10) return 5'(s);
                c++;
            end
        end
        return 5'b00000;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic en, input logic er, input logic ti,
                        input logic [3:0] nib, input logic [4:0] rs, input logic rd);
        logic [4:0] etx;
        string      ttag;
        logic       edv, eerr, efc;
        logic [3:0] enb, dn;
        bit         isd;
        tx_en = en; tx_er = er; tx_test_inv = ti; tx_nibble = nib;
        rx_sym = rs; status_rd = rd;
        case (txs)
            0: if (en) begin etx = 5'b11000; ttag = "R3"; txs = 1; end
               else begin etx = 5'b11111; ttag = "R2"; end
            1: begin etx = 5'b10001; ttag = "R3"; txs = 2; end
            2: if (!en) begin etx = 5'b01101; ttag = "R4"; txs = 3; end
               else if (er) begin etx = ti ? 5'b00000 : 5'b00100; ttag = ti ? "R6" : "R5"; end
               else begin etx = enc(nib); ttag = "R1"; end
            default: begin etx = 5'b00111; ttag = "R4"; txs = 0; end
        endcase
        isd = is_data(rs, dn);
        edv = 0; eerr = 0; efc = 0; enb = 4'h0;
        case (rxs)
            0: if (rs == 5'b11000) rxs = 1;
            1: if (rs == 5'b10001) rxs = 2; else begin efc = 1; rxs = 0; end
            2: if (rs == 5'b01101) rxs = 3;
               else begin edv = 1; if (isd) enb = dn; else eerr = 1; end
            default: rxs = 0;
        endcase
        inv_f  = (inv_f && !rd) || (!isd && !is_ctrl(rs));
        halt_f = (halt_f && !rd) || (rs == 5'b00100);
        @(posedge clk); #1;
        chk(tx_sym == etx, ttag, tx_sym, etx);
        chk(rx_dv == edv && rx_nibble == enb, "R7", {rx_dv, rx_nibble}, {edv, enb});
        chk(rx_err == eerr, "R9", rx_err, eerr);
        chk(rx_false_carrier == efc, "R8", rx_false_carrier, efc);
        chk(stat_invalid == inv_f && stat_halt == halt_f, rd ? "R11" : "R10",
            {stat_invalid, stat_halt}, {inv_f, halt_f});
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5.0);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(tx_sym == 5'b11111 && !rx_dv && !rx_err && !rx_false_carrier &&
            !stat_invalid && !stat_halt, "R12",
            {tx_sym, rx_dv, rx_err, rx_false_carrier, stat_invalid, stat_halt}, 10'h3E0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R3, R4, R7: full nibble sweep on both paths
        step(1, 0, 0, 4'h5, 5'b11000, 0);
        step(1, 0, 0, 4'h5, 5'b10001, 0);
        for (int n = 0; n < 16; n++) step(1, 0, 0, 4'(n), enc(4'(n)), 0);
        step(0, 0, 0, 0, 5'b01101, 0);
        step(0, 0, 0, 0, 5'b00111, 0);
        step(0, 0, 0, 0, 5'b11111, 0);
        // R5 and R6: error slots, halt and invalid inside a receive frame (R9)
        step(1, 0, 0, 0, 5'b11000, 0);
        step(1, 0, 0, 0, 5'b10001, 0);
        step(1, 1, 0, 4'h3, 5'b00100, 0);
        step(1, 1, 1, 4'h3, 5'b00000, 0);
        step(1, 0, 0, 4'h9, 5'b11111, 0);
        step(0, 0, 0, 0, 5'b01101, 0);
        step(0, 0, 0, 0, 5'b00111, 0);
        // R8: false carriers
        step(0, 0, 0, 0, 5'b11000, 0);
        step(0, 0, 0, 0, 5'b11111, 0);
        step(0, 0, 0, 0, 5'b11000, 0);
        step(0, 0, 0, 0, 5'b11000, 0);
        step(0, 0, 0, 0, 5'b11111, 0);
        // R10 outside a frame, R11 clear and collision
        step(0, 0, 0, 0, 5'b00011, 0);
        step(0, 0, 0, 0, 5'b11111, 0);
        step(0, 0, 0, 0, 5'b11111, 1);
        step(0, 0, 0, 0, 5'b00100, 0);
        step(0, 0, 0, 0, 5'b00100, 1);
        step(0, 0, 0, 0, 5'b00000, 1);
        step(0, 0, 0, 0, 5'b11111, 1);
        // constrained random
        begin
            int seed = $urandom(32'h1B5C);
            int remain = 0, gap = 0;
            logic ti = 0;
            logic [4:0] prev = 5'b11111;
            for (int i = 0; i < 4000; i++) begin
                logic en, er;
                logic [4:0] rs;
                int w;
                if (remain > 0) begin en = 1; remain--; end
                else if (gap > 0) begin en = 0; gap--; end
                else begin
                    remain = 2 + int'($urandom % 12);
                    gap = int'($urandom % 4);
                    ti = ($urandom % 3) == 0;
                    en = 0;
                end
                er = en && (($urandom % 8) == 0);
                w = int'($urandom % 100);
                if (prev == 5'b11000 && w < 80) rs = 5'b10001;
                else if (w < 40) rs = enc(4'($urandom));
                else if (w < 60) rs = 5'b11111;
                else if (w < 72) rs = 5'b11000;
                else if (w < 80) rs = 5'b01101;
                else if (w < 86) rs = 5'b00111;
                else if (w < 92) rs = 5'b00100;
                else rs = pick_invalid(int'($urandom % 10));
                prev = rs;
                step(en, er, ti, 4'($urandom), rs, ($urandom % 6) == 0);
            end
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule